// File: doc/BRIEF.md
# Register Rename Mapper with Checkpoint Restore

This block renames the architectural register specifiers of a dispatch group into physical register tags. A group holds up to four instruction lanes. Each lane may name two sources and one destination. Every destination that is renamed gets a fresh physical register, taken from a pool larger than the architectural set. Sources pick up the newest mapping, and that includes a destination written by an earlier lane of the same group. The translation is combinational: the tags are valid in the same cycle that the group is accepted.

Every accepted group takes one slot in a circular checkpoint buffer. The slot holds the map as it stood before the group, together with each lane's destination and new tag. The free pool is not kept as separate state. It is recomputed each cycle as every register that appears in neither of these:
- the committed (retired) map;
- a live allocation of a group still in the buffer.

Retiring the oldest group writes its tags into the committed map, so the registers they displaced become free. A redirect names a group and a lane. The speculative map is then rebuilt from that slot's snapshot plus the kept lanes. Every younger allocation drops out of the buffer, and its register becomes free again.

The dispatch side is a valid/ready stream. `in_ready` is the inverse of the stall condition, and it may depend on the group offered in the same cycle, because the group's destination count decides whether enough registers are free. A group moves only in a cycle where `in_valid` and `in_ready` are both high, and it is taken whole or not at all. The upstream stage keeps the same group on its inputs until it is taken. The renamed tags and `grp_tag` are meaningful only in the cycle the group is taken. Retire and redirect are plain control pins.

Top module: `rename_mapper`

## Requirements
- R1: After reset, architectural register r (0..30) maps to physical register r, physical register 31 is reserved, the free registers are 32..79, the buffer is empty, and `grp_tag` is 0.
- R2: Architectural register 31 is never renamed. A source naming it reads physical 31. A destination naming it allocates nothing and reports physical 31 on `dst_phys`.
- R3: A source with no earlier producer in its group reads the current speculative mapping.
- R4: Each lane that allocates (valid, write enabled, destination not 31) receives the lowest-numbered free register that no lower lane took. Lanes are served in order from lane 0, and the tags within one group are distinct.
- R5: A source naming the destination of an earlier lane in the same group receives that lane's new tag. When several earlier lanes write that register, the source takes the tag of the highest such lane.
- R6: `in_ready` is low when fewer free registers remain than the group needs. A group that needs no registers is accepted even when none are free.
- R7: The buffer holds 48 groups. While 48 groups are in flight, `in_ready` is low, including in a cycle where a retire is also requested.
- R8: `retire_valid` retires the oldest group. The registers that its lanes displaced are free from the next cycle.
- R9: A redirect with `redirect_excp`=0 restores the map as it stood after lane `redirect_lane` of group `redirect_grp`. All younger lanes and groups are squashed, and the next group accepted is tagged `redirect_grp`+1 modulo 48.
- R10: A redirect with `redirect_excp`=1 restores the map as it stood before lane `redirect_lane` of group `redirect_grp`, so that lane is squashed too.
- R11: Registers allocated by squashed lanes are free again from the cycle after the redirect.
- R12: `in_ready` is low in a cycle where `redirect_valid` is high.
- R13: `grp_tag` gives the buffer slot of the group being accepted. It increments by one per accepted group and wraps from 47 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Dispatch group offered |
| in_ready | output | 1 | Group can be taken; low means stall |
| lane_vld | input | 4 | Per-lane instruction present |
| dst_we | input | 4 | Per-lane destination written |
| dst_arch | input | 20 | Destination specifier, 5 bits per lane, lane 0 in the low bits |
| src_a_arch | input | 20 | First source specifier per lane |
| src_b_arch | input | 20 | Second source specifier per lane |
| src_a_phys | output | 28 | First source physical tag, 7 bits per lane |
| src_b_phys | output | 28 | Second source physical tag per lane |
| dst_phys | output | 28 | New destination tag per lane (31 if none allocated) |
| grp_tag | output | 6 | Buffer slot of the group being taken |
| retire_valid | input | 1 | Retire the oldest in-flight group |
| redirect_valid | input | 1 | Restore to a buffered point |
| redirect_excp | input | 1 | 1: squash the named lane too; 0: keep it |
| redirect_grp | input | 6 | Group slot of the restore point |
| redirect_lane | input | 2 | Lane of the restore point |

## Verification
The assertions assume the environment obeys the rules below.
- A redirect names a group that is still in flight.
- A retire never arrives in the same cycle as a redirect.
- A retire is requested only while the buffer holds a group.

The bench keeps to these rules. It issues redirects only to slots it has itself dispatched and not retired, and it keeps retire low in redirect cycles. A reference model computes every expected value, and the bench holds an offered group steady while `in_ready` is low.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_PHYS_REGS = 80;
  localparam int DEF_LANES     = 4;
  localparam int DEF_GROUPS    = 48;

  function automatic int wrap_inc(input int p, input int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rn_lane_xlate.sv
module rn_lane_xlate #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int LANES     = rn_pkg::DEF_LANES,
  parameter int AW        = 5,
  parameter int PW        = 7,
  parameter int CW        = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ARCH_REGS-1:0][PW-1:0]  map_i,
  input  logic [LANES-1:0]              vld_i,
  input  logic [LANES-1:0]              we_i,
  input  logic [LANES-1:0][AW-1:0]      dst_i,
  input  logic [LANES-1:0][AW-1:0]      sa_i,
  input  logic [LANES-1:0][AW-1:0]      sb_i,
  input  logic [LANES-1:0][PW-1:0]      pick_i,
  output logic [LANES-1:0][PW-1:0]      sa_o,
  output logic [LANES-1:0][PW-1:0]      sb_o,
  output logic [LANES-1:0][PW-1:0]      dst_o,
  output logic [LANES-1:0]              alloc_o,
  output logic [CW-1:0]                 need_o,
  output logic [ARCH_REGS-1:0][PW-1:0]  map_o
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [AW-1:0] ZA = AW'(ARCH_REGS - 1);
  localparam logic [PW-1:0] ZP = PW'(ARCH_REGS - 1);

  logic [ARCH_REGS-1:0][PW-1:0] work;
  logic [LW-1:0] idx;
  logic [CW-1:0] cnt;

  // Lanes in order: sources read the working map, which already holds earlier lanes' writes.
  always_comb begin
    work = map_i;
    idx  = '0;
    cnt  = '0;
    for (int i = 0; i < LANES; i++) begin
      alloc_o[i] = vld_i[i] && we_i[i] && (dst_i[i] != ZA);
      sa_o[i]    = work[sa_i[i]];
      sb_o[i]    = work[sb_i[i]];
      if (alloc_o[i]) begin
        dst_o[i]         = pick_i[idx];
        work[dst_i[i]]   = pick_i[idx];
        idx              = idx + LW'(1);
        cnt              = cnt + CW'(1);
      end else begin
        dst_o[i] = ZP;
      end
    end
    need_o = cnt;
    map_o  = work;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_zchk
    p_zero_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i[i] && sa_i[i] == ZA) |-> (sa_o[i] == ZP));
    for (genvar j = i + 1; j < LANES; j++) begin : g_pair
      p_dst_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_o[i] && alloc_o[j]) |-> (dst_o[i] != dst_o[j]));
    end
  end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
  parameter int LANES     = rn_pkg::DEF_LANES,
  parameter int GROUPS    = rn_pkg::DEF_GROUPS,
  parameter int PW        = 7
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [ARCH_REGS-1:0][PW-1:0]           ret_map_i,
  input  logic [GROUPS-1:0][LANES-1:0]           live_i,
  input  logic [GROUPS-1:0][LANES-1:0][PW-1:0]   tag_i,
  output logic [LANES-1:0][PW-1:0]               pick_o,
  output logic [PW:0]                            free_cnt_o
);
  logic [PHYS_REGS-1:0] in_use;
  int k;

  // Free set derived from committed map plus every live in-flight allocation.
  always_comb begin
    in_use = '0;
    for (int a = 0; a < ARCH_REGS; a++) in_use[ret_map_i[a]] = 1'b1;
    for (int g = 0; g < GROUPS; g++)
      for (int l = 0; l < LANES; l++)
        if (live_i[g][l]) in_use[tag_i[g][l]] = 1'b1;
  end

  always_comb begin
    pick_o     = '0;
    free_cnt_o = '0;
    k          = 0;
    for (int p = 0; p < PHYS_REGS; p++) begin
      if (!in_use[p]) begin
        if (k < LANES) pick_o[k] = PW'(p);
        k          = k + 1;
        free_cnt_o = free_cnt_o + (PW+1)'(1);
      end
    end
  end

  // Committed map names ARCH_REGS distinct registers, so the pool never grows beyond the spare count.
  p_pool_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt_o) <= PHYS_REGS - ARCH_REGS);
endmodule

// File: rtl/rename_mapper.sv
module rename_mapper #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
  parameter int LANES     = rn_pkg::DEF_LANES,
  parameter int GROUPS    = rn_pkg::DEF_GROUPS,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int GW = $clog2(GROUPS),
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES-1:0]     lane_vld,
  input  logic [LANES-1:0]     dst_we,
  input  logic [LANES*AW-1:0]  dst_arch,
  input  logic [LANES*AW-1:0]  src_a_arch,
  input  logic [LANES*AW-1:0]  src_b_arch,
  output logic [LANES*PW-1:0]  src_a_phys,
  output logic [LANES*PW-1:0]  src_b_phys,
  output logic [LANES*PW-1:0]  dst_phys,
  output logic [GW-1:0]        grp_tag,
  input  logic                 retire_valid,
  input  logic                 redirect_valid,
  input  logic                 redirect_excp,
  input  logic [GW-1:0]        redirect_grp,
  input  logic [LW-1:0]        redirect_lane
);
  localparam int CW = $clog2(LANES + 1);

  typedef logic [ARCH_REGS-1:0][PW-1:0] map_t;

  map_t                                spec_map_q, ret_map_q, next_map, rest_map;
  map_t                                snap_q [GROUPS];
  logic [GROUPS-1:0][LANES-1:0]        alloc_q, alloc_live;
  logic [GROUPS-1:0][LANES-1:0][AW-1:0] dst_q;
  logic [GROUPS-1:0][LANES-1:0][PW-1:0] new_q;
  logic [GW-1:0]                       head_q, tail_q;
  logic [GW:0]                         count_q;
  logic [GROUPS-1:0]                   grp_live;

  logic [LANES-1:0][AW-1:0] l_dst, l_sa, l_sb;
  logic [LANES-1:0][PW-1:0] x_sa, x_sb, x_dst, picks;
  logic [LANES-1:0]         x_alloc;
  logic [CW-1:0]            need;
  logic [PW:0]              free_cnt;
  logic [LW:0]              keep;
  logic                     fire, do_ret;
  int                       rd_off;

  assign l_dst      = dst_arch;
  assign l_sa       = src_a_arch;
  assign l_sb       = src_b_arch;
  assign src_a_phys = x_sa;
  assign src_b_phys = x_sb;
  assign dst_phys   = x_dst;
  assign grp_tag    = tail_q;

  // Which buffer slots lie inside the in-flight window.
  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      grp_live[g]   = ((g >= int'(head_q)) ? g - int'(head_q) : g + GROUPS - int'(head_q))
                      < int'(count_q);
      alloc_live[g] = alloc_q[g] & {LANES{grp_live[g]}};
    end
    rd_off = (int'(redirect_grp) >= int'(head_q)) ? int'(redirect_grp) - int'(head_q)
                                                  : int'(redirect_grp) + GROUPS - int'(head_q);
  end

  rn_free_pool #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .LANES(LANES),
                 .GROUPS(GROUPS), .PW(PW)) i_pool (
    .clk(clk), .rst_n(rst_n), .ret_map_i(ret_map_q), .live_i(alloc_live),
    .tag_i(new_q), .pick_o(picks), .free_cnt_o(free_cnt));

  rn_lane_xlate #(.ARCH_REGS(ARCH_REGS), .LANES(LANES), .AW(AW), .PW(PW), .CW(CW)) i_xlate (
    .clk(clk), .rst_n(rst_n), .map_i(spec_map_q), .vld_i(lane_vld), .we_i(dst_we),
    .dst_i(l_dst), .sa_i(l_sa), .sb_i(l_sb), .pick_i(picks), .sa_o(x_sa), .sb_o(x_sb),
    .dst_o(x_dst), .alloc_o(x_alloc), .need_o(need), .map_o(next_map));

  assign in_ready = !redirect_valid && (int'(count_q) != GROUPS) && (int'(free_cnt) >= int'(need));
  assign fire     = in_valid && in_ready;
  assign do_ret   = retire_valid && !redirect_valid && (count_q != '0);

  // Restore point: snapshot before the group plus the lanes that survive.
  always_comb begin
    keep     = {1'b0, redirect_lane} + ((LW+1)'(!redirect_excp));
    rest_map = snap_q[redirect_grp];
    for (int l = 0; l < LANES; l++)
      if ((LW+1)'(l) < keep && alloc_q[redirect_grp][l])
        rest_map[dst_q[redirect_grp][l]] = new_q[redirect_grp][l];
  end

  always_ff @(posedge clk) begin
    if (fire) snap_q[tail_q] <= spec_map_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        spec_map_q[a] <= PW'(a);
        ret_map_q[a]  <= PW'(a);
      end
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      alloc_q <= '0;
      dst_q   <= '0;
      new_q   <= '0;
    end else if (redirect_valid) begin
      spec_map_q <= rest_map;
      for (int l = 0; l < LANES; l++)
        if ((LW+1)'(l) >= keep) alloc_q[redirect_grp][l] <= 1'b0;
      tail_q  <= GW'(rn_pkg::wrap_inc(int'(redirect_grp), GROUPS));
      count_q <= (GW+1)'(rd_off + 1);
    end else begin
      if (fire) begin
        alloc_q[tail_q] <= x_alloc;
        dst_q[tail_q]   <= l_dst;
        new_q[tail_q]   <= x_dst;
        spec_map_q      <= next_map;
        tail_q          <= GW'(rn_pkg::wrap_inc(int'(tail_q), GROUPS));
      end
      if (do_ret) begin
        for (int l = 0; l < LANES; l++)
          if (alloc_q[head_q][l]) ret_map_q[dst_q[head_q][l]] <= new_q[head_q][l];
        head_q <= GW'(rn_pkg::wrap_inc(int'(head_q), GROUPS));
      end
      count_q <= count_q + (GW+1)'(fire) - (GW+1)'(do_ret);
    end
  end

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= GROUPS);
  p_restore_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (int'(tail_q) == rn_pkg::wrap_inc(int'($past(redirect_grp)), GROUPS)));
  p_restore_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> grp_live[redirect_grp]);
  p_retire_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !redirect_valid && count_q != '0 && !(in_valid && in_ready))
    |=> (count_q == $past(count_q) - (GW+1)'(1)));
  p_zero_committed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_map_q[ARCH_REGS-1] == PW'(ARCH_REGS - 1));
endmodule

// File: tb/test_rename_mapper.sv
module test_rename_mapper;
  localparam int PERIOD = 8;
  localparam int NG = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid, in_ready, retire_valid, redirect_valid, redirect_excp;
  logic [3:0] lane_vld, dst_we;
  logic [19:0] dst_arch, src_a_arch, src_b_arch;
  logic [27:0] src_a_phys, src_b_phys, dst_phys;
  logic [5:0] grp_tag, redirect_grp;
  logic [1:0] redirect_lane;

  always #(PERIOD/2) clk = ~clk;

  rename_mapper i_rename_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lane_vld(lane_vld), .dst_we(dst_we), .dst_arch(dst_arch),
    .src_a_arch(src_a_arch), .src_b_arch(src_b_arch), .src_a_phys(src_a_phys),
    .src_b_phys(src_b_phys), .dst_phys(dst_phys), .grp_tag(grp_tag),
    .retire_valid(retire_valid), .redirect_valid(redirect_valid),
    .redirect_excp(redirect_excp), .redirect_grp(redirect_grp),
    .redirect_lane(redirect_lane));

  // Stimulus table: lane 3 in the high bits, lane 0 in the low bits.
  localparam int NROW = 8;
  localparam logic [3:0]  T_VLD [NROW] = '{4'hf, 4'h3, 4'hf, 4'hf, 4'hf, 4'h1, 4'h0, 4'hf};
  localparam logic [3:0]  T_WE  [NROW] = '{4'hf, 4'h1, 4'hf, 4'h0, 4'hf, 4'h1, 4'h0, 4'ha};
  localparam logic [19:0] T_DST [NROW] = '{
    {5'd4, 5'd3, 5'd2, 5'd1}, {5'd0, 5'd0, 5'd7, 5'd1}, {5'd5, 5'd5, 5'd5, 5'd5},
    {5'd0, 5'd0, 5'd0, 5'd0}, {5'd31, 5'd31, 5'd6, 5'd6}, {5'd0, 5'd0, 5'd0, 5'd8},
    {5'd0, 5'd0, 5'd0, 5'd0}, {5'd2, 5'd9, 5'd1, 5'd9}};
  localparam logic [19:0] T_SA [NROW] = '{
    {5'd3, 5'd2, 5'd1, 5'd0}, {5'd0, 5'd0, 5'd1, 5'd1}, {5'd5, 5'd5, 5'd5, 5'd5},
    {5'd10, 5'd1, 5'd5, 5'd31}, {5'd6, 5'd6, 5'd6, 5'd31}, {5'd0, 5'd0, 5'd0, 5'd8},
    {5'd0, 5'd0, 5'd0, 5'd0}, {5'd9, 5'd9, 5'd1, 5'd2}};
  localparam logic [19:0] T_SB [NROW] = '{
    {5'd4, 5'd3, 5'd2, 5'd1}, {5'd0, 5'd0, 5'd31, 5'd9}, {5'd1, 5'd2, 5'd3, 5'd4},
    {5'd7, 5'd6, 5'd2, 5'd1}, {5'd2, 5'd6, 5'd31, 5'd6}, {5'd8, 5'd0, 5'd0, 5'd1},
    {5'd0, 5'd0, 5'd0, 5'd0}, {5'd2, 5'd1, 5'd9, 5'd9}};
  localparam logic        T_RET [NROW] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic        T_RDY [NROW] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  int total = 0, bad = 0;
  bit done = 0;

  logic [3:0] lv, lw;
  int da[4], sa[4], sb[4];
  int obs_sa[4], obs_sb[4], obs_dst[4], obs_tag;
  logic obs_rdy;

  // Reference model: explicit free list and per-slot records.
  int mmap[32];
  bit mfree[80];
  int mhead, mtail, mcount;
  int s_snap[NG][32];
  bit s_al[NG][4];
  int s_dst[NG][4], s_new[NG][4], s_old[NG][4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 32; a++) mmap[a] = a;
    for (int p = 0; p < 80; p++) mfree[p] = (p >= 32);
    mhead = 0; mtail = 0; mcount = 0;
    for (int g = 0; g < NG; g++) for (int l = 0; l < 4; l++) s_al[g][l] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 0; retire_valid = 0; redirect_valid = 0; redirect_excp = 0;
    redirect_grp = '0; redirect_lane = '0; lane_vld = '0; dst_we = '0;
    dst_arch = '0; src_a_arch = '0; src_b_arch = '0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_lanes(input logic [3:0] v, input logic [3:0] w, input logic [19:0] d,
                           input logic [19:0] a, input logic [19:0] b);
    lv = v; lw = w;
    for (int i = 0; i < 4; i++) begin
      da[i] = int'(d[i*5 +: 5]); sa[i] = int'(a[i*5 +: 5]); sb[i] = int'(b[i*5 +: 5]);
    end
  endtask

  task automatic step(input bit v, input bit rt, input bit rd, input bit rex,
                      input int rg, input int rl, input string req);
    int tmap[32];
    bit tfree[80];
    int e_sa[4], e_sb[4], e_dst[4], e_old[4];
    bit e_al[4];
    int need, nfree, keep, idx, off;
    bit e_rdy;
    @(negedge clk);
    in_valid = v; retire_valid = rt; redirect_valid = rd; redirect_excp = rex;
    redirect_grp = 6'(rg); redirect_lane = 2'(rl);
    lane_vld = lv; dst_we = lw;
    for (int i = 0; i < 4; i++) begin
      dst_arch[i*5 +: 5] = 5'(da[i]); src_a_arch[i*5 +: 5] = 5'(sa[i]);
      src_b_arch[i*5 +: 5] = 5'(sb[i]);
    end
    #1;
    for (int a = 0; a < 32; a++) tmap[a] = mmap[a];
    nfree = 0;
    for (int p = 0; p < 80; p++) begin tfree[p] = mfree[p]; if (mfree[p]) nfree++; end
    need = 0;
    for (int i = 0; i < 4; i++) begin
      e_al[i] = lv[i] && lw[i] && da[i] != 31;
      e_sa[i] = tmap[sa[i]]; e_sb[i] = tmap[sb[i]]; e_dst[i] = 31; e_old[i] = 0;
      if (e_al[i]) begin
        need++;
        for (int p = 0; p < 80; p++)
          if (tfree[p] && e_dst[i] == 31) begin e_dst[i] = p; tfree[p] = 0; end
        e_old[i] = tmap[da[i]];
        tmap[da[i]] = e_dst[i];
      end
    end
    e_rdy = !rd && mcount < NG && nfree >= need;
    obs_rdy = in_ready; obs_tag = int'(grp_tag);
    for (int i = 0; i < 4; i++) begin
      obs_sa[i] = int'(src_a_phys[i*7 +: 7]); obs_sb[i] = int'(src_b_phys[i*7 +: 7]);
      obs_dst[i] = int'(dst_phys[i*7 +: 7]);
    end
    chk(obs_rdy == e_rdy, {req, " ready"}, int'(obs_rdy), int'(e_rdy));
    if (v && e_rdy) begin
      chk(obs_tag == mtail, {req, " R13 tag"}, obs_tag, mtail);
      for (int i = 0; i < 4; i++) if (lv[i]) begin
        chk(obs_sa[i] == e_sa[i], {req, " src_a"}, obs_sa[i], e_sa[i]);
        chk(obs_sb[i] == e_sb[i], {req, " src_b"}, obs_sb[i], e_sb[i]);
        chk(obs_dst[i] == e_dst[i], {req, " dst"}, obs_dst[i], e_dst[i]);
      end
    end
    @(posedge clk);
    if (rd) begin
      keep = rl + (rex ? 0 : 1);
      for (int a = 0; a < 32; a++) mmap[a] = s_snap[rg][a];
      for (int l = 0; l < 4; l++) if (s_al[rg][l]) begin
        if (l < keep) mmap[s_dst[rg][l]] = s_new[rg][l];
        else begin mfree[s_new[rg][l]] = 1; s_al[rg][l] = 0; end
      end
      idx = (rg + 1) % NG;
      while (idx != mtail) begin
        for (int l = 0; l < 4; l++) if (s_al[idx][l]) begin
          mfree[s_new[idx][l]] = 1; s_al[idx][l] = 0;
        end
        idx = (idx + 1) % NG;
      end
      off = (rg - mhead + NG) % NG;
      mtail = (rg + 1) % NG;
      mcount = off + 1;
    end else begin
      if (v && e_rdy) begin
        for (int a = 0; a < 32; a++) begin s_snap[mtail][a] = mmap[a]; mmap[a] = tmap[a]; end
        for (int l = 0; l < 4; l++) begin
          s_al[mtail][l] = e_al[l]; s_dst[mtail][l] = da[l];
          s_new[mtail][l] = e_dst[l]; s_old[mtail][l] = e_old[l];
          if (e_al[l]) mfree[e_dst[l]] = 0;
        end
        mtail = (mtail + 1) % NG;
        mcount++;
      end
      if (rt && mcount > 0) begin
        for (int l = 0; l < 4; l++) if (s_al[mhead][l]) mfree[s_old[mhead][l]] = 1;
        mhead = (mhead + 1) % NG;
        mcount--;
      end
    end
  endtask

  initial begin
    do_reset();
    // R1: reset state
    set_lanes(4'h0, 4'h0, '0, '0, '0);
    step(0, 0, 0, 0, 0, 0, "R1");
    chk(obs_rdy == 1'b1, "R1 ready after reset", int'(obs_rdy), 1);
    chk(obs_tag == 0, "R1 tag after reset", obs_tag, 0);

    // Table walk: R3 R4 R5
    for (int r = 0; r < NROW; r++) begin
      set_lanes(T_VLD[r], T_WE[r], T_DST[r], T_SA[r], T_SB[r]);
      step(T_VLD[r] != 4'h0, T_RET[r], 0, 0, 0, 0, "R3 R4 R5");
      chk(obs_rdy == T_RDY[r], "R6 table ready", int'(obs_rdy), int'(T_RDY[r]));
      if (r == 0) begin
        chk(obs_dst[0] == 32, "R1 first allocation", obs_dst[0], 32);
        chk(obs_sa[0] == 0, "R1 identity map", obs_sa[0], 0);
        chk(obs_sa[1] == 32, "R5 bypass lane1", obs_sa[1], 32);
      end
    end

    // R2: zero register
    do_reset();
    set_lanes(4'h1, 4'h1, {15'd0, 5'd31}, {15'd0, 5'd31}, {15'd0, 5'd3});
    step(1, 0, 0, 0, 0, 0, "R2");
    chk(obs_dst[0] == 31, "R2 no rename of r31", obs_dst[0], 31);
    chk(obs_sa[0] == 31, "R2 r31 source", obs_sa[0], 31);
    set_lanes(4'h1, 4'h1, {15'd0, 5'd2}, {15'd0, 5'd31}, {15'd0, 5'd2});
    step(1, 0, 0, 0, 0, 0, "R2");
    chk(obs_dst[0] == 32, "R2 pool untouched", obs_dst[0], 32);

    // R6 / R8: exhaust the pool, then retire
    do_reset();
    set_lanes(4'hf, 4'hf, {5'd4, 5'd3, 5'd2, 5'd1}, {5'd1, 5'd2, 5'd3, 5'd4}, {5'd0, 5'd0, 5'd0, 5'd0});
    for (int n = 0; n < 12; n++) step(1, 0, 0, 0, 0, 0, "R4");
    set_lanes(4'h1, 4'h1, {15'd0, 5'd9}, {15'd0, 5'd1}, {15'd0, 5'd2});
    step(1, 0, 0, 0, 0, 0, "R6");
    chk(obs_rdy == 1'b0, "R6 stall on empty pool", int'(obs_rdy), 0);
    set_lanes(4'hf, 4'h0, {5'd4, 5'd3, 5'd2, 5'd1}, {5'd1, 5'd2, 5'd3, 5'd4}, '0);
    step(1, 0, 0, 0, 0, 0, "R6");
    chk(obs_rdy == 1'b1, "R6 zero-need group", int'(obs_rdy), 1);
    step(0, 1, 0, 0, 0, 0, "R8");
    set_lanes(4'h1, 4'h1, {15'd0, 5'd9}, {15'd0, 5'd1}, {15'd0, 5'd2});
    step(1, 0, 0, 0, 0, 0, "R8");
    chk(obs_dst[0] == 1, "R8 displaced reg reused", obs_dst[0], 1);

    // R9 R10 R11 R12: restores
    do_reset();
    set_lanes(4'hf, 4'hf, {5'd4, 5'd3, 5'd2, 5'd1}, {5'd6, 5'd7, 5'd8, 5'd9}, {5'd1, 5'd2, 5'd3, 5'd4});
    for (int n = 0; n < 5; n++) step(1, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 1, 0, 1, 1, "R12");
    chk(obs_rdy == 1'b0, "R12 no dispatch on redirect", int'(obs_rdy), 0);
    set_lanes(4'hf, 4'hf, {5'd8, 5'd7, 5'd6, 5'd5}, {5'd4, 5'd3, 5'd2, 5'd1}, {5'd1, 5'd2, 5'd3, 5'd4});
    step(1, 0, 0, 0, 0, 0, "R9");
    chk(obs_tag == 2, "R9 tag after restore", obs_tag, 2);
    chk(obs_sa[0] == 36, "R9 kept lane", obs_sa[0], 36);
    chk(obs_sa[2] == 34, "R9 older group", obs_sa[2], 34);
    chk(obs_dst[0] == 38, "R11 squashed reg reused", obs_dst[0], 38);
    step(0, 0, 1, 1, 2, 0, "R10");
    set_lanes(4'hf, 4'h0, '0, {5'd3, 5'd2, 5'd1, 5'd5}, {5'd8, 5'd7, 5'd6, 5'd5});
    step(1, 0, 0, 0, 0, 0, "R10");
    chk(obs_sa[0] == 5, "R10 faulting lane undone", obs_sa[0], 5);
    chk(obs_sa[1] == 36, "R10 older map kept", obs_sa[1], 36);
    chk(obs_tag == 3, "R13 tag after exception", obs_tag, 3);
    set_lanes(4'h3, 4'h3, {10'd0, 5'd2, 5'd1}, '0, '0);
    step(1, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 1, 0, 3, 1, "R9");
    step(1, 0, 0, 0, 0, 0, "R11");

    // R7 / R13: fill the buffer
    do_reset();
    set_lanes(4'hf, 4'h0, '0, {5'd1, 5'd2, 5'd3, 5'd4}, '0);
    for (int n = 0; n < NG; n++) step(1, 0, 0, 0, 0, 0, "R13");
    step(1, 0, 0, 0, 0, 0, "R7");
    chk(obs_rdy == 1'b0, "R7 full buffer", int'(obs_rdy), 0);
    step(1, 1, 0, 0, 0, 0, "R7");
    chk(obs_rdy == 1'b0, "R7 full with retire", int'(obs_rdy), 0);
    step(1, 0, 0, 0, 0, 0, "R13");
    chk(obs_tag == 0, "R13 wrap", obs_tag, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule